// File: doc/BRIEF.md
# Carry-Out and Saturation-Select ALU

This block is an arithmetic slice that offers wide and saturating integer arithmetic as separate operations, each with a single result. It has no flag outputs and no dedicated saturating adders. Software builds a multi-word add from three pieces: a plain add, an add that returns only the carry, and a three-operand add. It builds a saturating add from a plain add, a carry-returning add and a selection step. The selection step takes the high part and either passes the low result through or replaces it with a bound. A nonzero high part means overflow.

Each request carries a 3-bit operation code and three W-bit operands, `opa`, `opb` and `opc`, and is qualified by `in_valid`. The operation is computed combinationally. The result is captured in an output register on the next rising clock edge, and `res_valid` is raised for that one cycle. Reset is synchronous and active high.

Top module: `chainalu`

## Requirements
- R1: While `rst` is sampled high, the block clears `res` to zero and drives `res_valid` low on the following edge.
- R2: `res_valid` is high in exactly the cycles after an edge at which `in_valid` was high, and low otherwise.
- R3: Code 3'b000 (add) returns (opa + opb) mod 2^W.
- R4: Code 3'b001 (add-high) returns the carry out of the W-bit sum opa + opb, zero-extended, so the result is 0 or 1.
- R5: Code 3'b010 (three-input add) returns (opa + opb + opc) mod 2^W.
- R6: Code 3'b011 (three-input carry) returns floor((opa + opb + opc) / 2^W), zero-extended, so the result is in 0..2.
- R7: Code 3'b100 (signed select) returns opb when opa is zero.
- R8: Code 3'b100 with nonzero opa returns 2^(W-1)-1 when opa is positive as a two's-complement value. It returns 2^(W-1) (the most negative value) when opa is negative.
- R9: Code 3'b101 (unsigned select) returns opb when opa is zero and the all-ones word otherwise.
- R10: Codes 3'b110 and 3'b111 return zero.
- R11: While `in_valid` is low, `res` keeps its last value whatever the other inputs do.
- R12: Chaining add, add-high and three-input add (with the carry as opc), plus three-input carry, on the halves of two 2W-bit numbers gives their 2W-bit sum and its carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request qualifier |
| op | input | 3 | Operation code |
| opa | input | W | First operand (high part for the select codes) |
| opb | input | W | Second operand (pass-through value for the select codes) |
| opc | input | W | Third operand or carry-in |
| res_valid | output | 1 | Result qualifier, one cycle after the request |
| res | output | W | Registered result |

## Verification
The hardest result to reach is the three-input carry value of 2. It needs all three operands to be large together, so that their sum reaches at least 2^(W+1). With a 16-bit word almost no directed pattern lands there. The bench therefore builds the block with a 4-bit word and sweeps every code against every operand triple. That covers the carry value of 2, the sign boundary of the signed select and every zero/nonzero case of the first operand. A strided sweep of 8-bit chained additions then checks that the pieces compose correctly.

// File: rtl/chainalu_pkg.sv
package chainalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD     = 3'd0,
        OP_ADDHI   = 3'd1,
        OP_ADD3    = 3'd2,
        OP_ADD3CY  = 3'd3,
        OP_SELS    = 3'd4,
        OP_SELU    = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic sum2;
        logic hi2;
        logic sum3;
        logic hi3;
        logic sels;
        logic selu;
    } op_sel_t;

    function automatic op_sel_t decode_op(input alu_op_e code);
        op_sel_t s;
        s = '0;
        case (code)
            OP_ADD:    s.sum2 = 1'b1;
            OP_ADDHI:  s.hi2  = 1'b1;
            OP_ADD3:   s.sum3 = 1'b1;
            OP_ADD3CY: s.hi3  = 1'b1;
            OP_SELS:   s.sels = 1'b1;
            OP_SELU:   s.selu = 1'b1;
            default:   s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/chainalu_adder.sv
module chainalu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum2,
    output logic [W-1:0] hi2,
    output logic [W-1:0] sum3,
    output logic [W-1:0] hi3
);
    localparam int S2W = W + 1;
    localparam int S3W = W + 2;

    logic [S2W-1:0] wide2;
    logic [S3W-1:0] wide3;

    always_comb begin
        wide2 = {1'b0, a} + {1'b0, b};
        wide3 = {2'b00, a} + {2'b00, b} + {2'b00, c};
    end

    assign sum2 = wide2[W-1:0];
    assign hi2  = {{(W-1){1'b0}}, wide2[W]};
    assign sum3 = wide3[W-1:0];
    assign hi3  = {{(W-2){1'b0}}, wide3[W+1:W]};

endmodule

// File: rtl/chainalu_sel.sv
module chainalu_sel #(
    parameter int W = 16
) (
    input  logic [W-1:0] hi,
    input  logic [W-1:0] pass,
    output logic [W-1:0] sat_s,
    output logic [W-1:0] sat_u
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] UMAX = {W{1'b1}};

    logic hi_zero;
    assign hi_zero = (hi == '0);

    always_comb begin
        if (hi_zero)
            sat_s = pass;
        else if (hi[W-1])
            sat_s = SMIN;
        else
            sat_s = SMAX;
        sat_u = hi_zero ? pass : UMAX;
    end

endmodule

// File: rtl/chainalu.sv
module chainalu
    import chainalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [2:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] opc,
    output logic         res_valid,
    output logic [W-1:0] res
);
    logic [W-1:0] sum2, hi2, sum3, hi3, sat_s, sat_u;
    logic [W-1:0] nxt;
    op_sel_t      sel;

    chainalu_adder #(.W(W)) u_add (
        .a(opa), .b(opb), .c(opc),
        .sum2(sum2), .hi2(hi2), .sum3(sum3), .hi3(hi3)
    );

    chainalu_sel #(.W(W)) u_sel (
        .hi(opa), .pass(opb), .sat_s(sat_s), .sat_u(sat_u)
    );

    assign sel = decode_op(alu_op_e'(op));

    // AND-OR mux over a one-hot select; reserved codes select nothing
    always_comb begin
        nxt = ({W{sel.sum2}} & sum2)
            | ({W{sel.hi2}}  & hi2)
            | ({W{sel.sum3}} & sum3)
            | ({W{sel.hi3}}  & hi3)
            | ({W{sel.sels}} & sat_s)
            | ({W{sel.selu}} & sat_u);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid)
                res <= nxt;
        end
    end

endmodule

// File: rtl/chainalu_chk.sv
module chainalu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [2:0]   op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         res_valid,
    input logic [W-1:0] res
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);
    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res));
    // R4
    addhi_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd1) |=> (res <= 1));
    // R6
    add3cy_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd3) |=> (res <= 2));
    // R7
    sels_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd4 && opa == '0) |=> (res == $past(opb)));
    // R9
    selu_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd5 && opa != '0) |=> (&res));
    // R10
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2:1] == 2'b11) |=> (res == '0));
endmodule

bind chainalu chainalu_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .res_valid(res_valid), .res(res)
);

// File: tb/tb_chainalu.sv
`timescale 1ns/100ps
module tb_chainalu;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   op;
    logic [W-1:0] opa, opb, opc;
    logic         res_valid;
    logic [W-1:0] res;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    chainalu #(.W(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .opc(opc),
        .res_valid(res_valid), .res(res)
    );

    function automatic int expect_of(int code, int a, int b, int c);
        int s;
        case (code)
            0: return (a + b) & MASK;
            1: return (a + b) >> W;
            2: return (a + b + c) & MASK;
            3: return (a + b + c) >> W;
            4: begin
                if (a == 0) s = b;
                else if (a >= (1 << (W - 1))) s = 1 << (W - 1);
                else s = (1 << (W - 1)) - 1;
                return s;
            end
            5: return (a == 0) ? b : MASK;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int code, int a);
        case (code)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return (a == 0) ? "R7" : "R8";
            5: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(int code, int a, int b, int c, output int r);
        @(negedge clk);
        in_valid = 1'b1;
        op  = code[2:0];
        opa = a[W-1:0];
        opb = b[W-1:0];
        opc = c[W-1:0];
        @(negedge clk);
        in_valid = 1'b0;
        r = int'(res);
        check("R2", int'(res_valid), 1);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int r;
        rst = 1'b1; in_valid = 1'b1; op = 3'd5; opa = 4'd3; opb = 4'd1; opc = 4'd0;
        repeat (3) @(negedge clk);
        // R1: reset clears result and qualifier even with in_valid high
        check("R1", int'(res), 0);
        check("R1", int'(res_valid), 0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R2", int'(res_valid), 0);

        // R3..R10: every code against every operand triple
        for (int code = 0; code < 8; code++)
            for (int a = 0; a <= MASK; a++)
                for (int b = 0; b <= MASK; b++)
                    for (int c = 0; c <= MASK; c++) begin
                        run(code, a, b, c, r);
                        check(tag_of(code, a), r, expect_of(code, a, b, c));
                    end

        // R11: inputs toggle with in_valid low; result and qualifier hold
        run(2, 7, 5, 1, r);
        check("R5", r, 13);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            op = 3'(k); opa = 4'(k * 3); opb = 4'(k + 9); opc = 4'(15 - k);
            @(negedge clk);
            check("R11", int'(res), 13);
            check("R2", int'(res_valid), 0);
        end

        // R12: 8-bit addition assembled from 4-bit pieces
        for (int x = 0; x < 256; x += 7)
            for (int y = 0; y < 256; y += 11) begin
                int lo, cy, hi, co, got;
                run(0, x & MASK, y & MASK, 0, lo);
                run(1, x & MASK, y & MASK, 0, cy);
                run(2, x >> W, y >> W, cy, hi);
                run(3, x >> W, y >> W, cy, co);
                got = (co << (2 * W)) | (hi << W) | lo;
                check("R12", got, x + y);
            end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule